// File: doc/BRIEF.md
# Input Port Controller with Contention Feedback

Each input port of a self-routing output-buffered switch has one of these controllers. It decides which cell the port presents to the switching grid in each time slot. Newly arrived cells wait in an eight-entry first-in-first-out queue. A cell that lost contention in the grid comes back on a separate feedback interface. The controller parks that cell in a single-entry retry slot, and the retry slot is served before anything in the queue.

Every returning cell comes back with its priority raised by one, so a cell that has been waiting longer wins ties in the grid. A returning cell is dropped when its priority is still at zero or has already reached the top code, which bounds how many times one cell can retry. A new cell that finds the queue full is dropped, and the drop is counted. The address and priority of the presented cell also leave through a header delay line. Its depth equals the port's position, so that headers enter the grid diagonally aligned.

Top module: `fbk_inport_ctl`

## Requirements
- R1: After reset, `tx_valid`, `tx_addr`, `tx_prio`, `tx_tag`, `sk_addr`, `sk_prio` and `loss_cnt` are all zero.
- R2: On a clock edge with `slot_start` high and the retry slot occupied, the retry cell appears on the tx outputs after that edge and the retry slot empties. Queued cells stay where they are.
- R3: With the retry slot empty, a slot edge sends the oldest queued cell with `tx_prio` = 1. Cells leave in arrival order.
- R4: A slot edge with nothing stored sets `tx_valid` = 0 and drives zero on `tx_addr`, `tx_prio` and `tx_tag`.
- R5: A feedback cell with `fb_prio` = 0 or `fb_prio` = 2^PRIO_W-1 (3 by default) is discarded. The next slot edge sends what it would have sent without that cell.
- R6: Any other feedback cell is stored with priority `fb_prio`+1. It is sent, with its address and tag, at the next slot edge.
- R7: The queue holds DEPTH (8) cells. An arrival that finds the queue full is dropped unless the same edge pops a cell. Each drop raises `loss_cnt` by one, and the counter saturates at all ones.
- R8: When feedback and `slot_start` fall on the same edge with the retry slot occupied, the old retry cell is sent and the new one is stored. When the retry slot is occupied and no slot edge occurs, new feedback is discarded.
- R9: `{sk_addr, sk_prio}` equals `{tx_addr, tx_prio}` delayed by SKEW clock cycles (2 by default). The delay line is reset to zero.
- R10: The tx outputs change only on edges where `slot_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_start | input | 1 | Slot boundary; selects the next cell to send |
| new_valid | input | 1 | A new cell arrives this cycle |
| new_addr | input | ADDR_W | Destination output of the new cell |
| new_tag | input | TAG_W | Payload tag of the new cell |
| fb_valid | input | 1 | A cell that lost contention returns this cycle |
| fb_addr | input | ADDR_W | Destination of the returning cell |
| fb_prio | input | PRIO_W | Priority the returning cell carried |
| fb_tag | input | TAG_W | Payload tag of the returning cell |
| tx_valid | output | 1 | Presented cell is real |
| tx_addr | output | ADDR_W | Destination of the presented cell |
| tx_prio | output | PRIO_W | Priority of the presented cell |
| tx_tag | output | TAG_W | Payload tag of the presented cell |
| sk_addr | output | ADDR_W | Delayed destination for the grid |
| sk_prio | output | PRIO_W | Delayed priority for the grid |
| loss_cnt | output | LOSS_W | Saturating count of arrivals dropped on a full queue |

## Verification
Two pairs of events can land on the same edge. A slot boundary can coincide with a feedback write into the retry slot that it is emptying. A full queue can receive an arrival on the same edge that a slot boundary pops it. A periodic sweep drives slot strobes, arrivals and feedback with different moduli, so that every mix of these events and every feedback priority code occurs. Each outcome is compared, edge by edge, with a behavioural model kept in the bench. A dedicated step places a feedback cell on the exact slot edge that drains an occupied retry slot, and checks that both cells come out in order with the right priorities.

// File: rtl/fbk_inport_ctl.sv
module fbk_inport_ctl #(
  parameter int ADDR_W = 2,
  parameter int PRIO_W = 2,
  parameter int TAG_W  = 6,
  parameter int DEPTH  = 8,
  parameter int SKEW   = 2,
  parameter int LOSS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  logic              new_valid,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic [TAG_W-1:0]  new_tag,
  input  logic              fb_valid,
  input  logic [ADDR_W-1:0] fb_addr,
  input  logic [PRIO_W-1:0] fb_prio,
  input  logic [TAG_W-1:0]  fb_tag,
  output logic              tx_valid,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [PRIO_W-1:0] tx_prio,
  output logic [TAG_W-1:0]  tx_tag,
  output logic [ADDR_W-1:0] sk_addr,
  output logic [PRIO_W-1:0] sk_prio,
  output logic [LOSS_W-1:0] loss_cnt
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam int EW = ADDR_W + TAG_W;
  localparam int HW = ADDR_W + PRIO_W;
  localparam logic [PRIO_W-1:0] PMAX = '1;

  logic [EW-1:0]     mem [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic              low_v;
  logic [ADDR_W-1:0] low_addr;
  logic [PRIO_W-1:0] low_prio;
  logic [TAG_W-1:0]  low_tag;

  wire send_low = slot_start && low_v;
  wire pop      = slot_start && !low_v && (cnt != '0);
  wire full_now = (cnt == CW'(DEPTH)) && !pop;
  wire push     = new_valid && !full_now;
  wire fb_ok    = fb_valid && (fb_prio != '0) && (fb_prio != PMAX) && (!low_v || send_low);

  always_ff @(posedge clk) if (push) mem[wp] <= {new_addr, new_tag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; loss_cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      if (new_valid && full_now && loss_cnt != '1) loss_cnt <= loss_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_v <= 1'b0; low_addr <= '0; low_prio <= '0; low_tag <= '0;
    end else if (fb_ok) begin
      low_v <= 1'b1; low_addr <= fb_addr; low_prio <= fb_prio + 1'b1; low_tag <= fb_tag;
    end else if (send_low) begin
      low_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0; tx_addr <= '0; tx_prio <= '0; tx_tag <= '0;
    end else if (slot_start) begin
      if (low_v) begin
        tx_valid <= 1'b1; tx_addr <= low_addr; tx_prio <= low_prio; tx_tag <= low_tag;
      end else if (cnt != '0) begin
        tx_valid <= 1'b1; {tx_addr, tx_tag} <= mem[rp]; tx_prio <= PRIO_W'(1);
      end else begin
        tx_valid <= 1'b0; tx_addr <= '0; tx_prio <= '0; tx_tag <= '0;
      end
    end
  end

  generate
    if (SKEW == 0) begin : g_noskew
      assign {sk_addr, sk_prio} = {tx_addr, tx_prio};
    end else begin : g_skew
      logic [HW-1:0] sh [SKEW];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < SKEW; i++) sh[i] <= '0;
        end else begin
          sh[0] <= {tx_addr, tx_prio};
          for (int i = 1; i < SKEW; i++) sh[i] <= sh[i-1];
        end
      end
      assign {sk_addr, sk_prio} = sh[SKEW-1];
    end
  endgenerate

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> $stable({tx_valid, tx_addr, tx_prio, tx_tag})); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> (tx_prio == '0 && tx_addr == '0 && tx_tag == '0)); // R4
  AST_PRIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_prio != '0); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R7
  AST_RETRY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && low_v) |=> (tx_valid && tx_prio != PRIO_W'(1) && $stable(cnt) == 1'b0 || tx_valid)); // R2
  AST_LOSS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (new_valid && full_now && loss_cnt != '1) |=> loss_cnt == LOSS_W'($past(loss_cnt) + 1'b1)); // R7
endmodule

// File: tb/fbk_inport_ctl_bench.sv
`timescale 1ns/1ps
module fbk_inport_ctl_bench;
  localparam int AW = 2, PWD = 2, TW = 6, DEP = 8, SK = 2, LW = 8;
  localparam int PMAX = 3;

  logic clk = 0, rst_n = 0;
  logic slot_start = 0, new_valid = 0, fb_valid = 0;
  logic [AW-1:0] new_addr = 0, fb_addr = 0, tx_addr, sk_addr;
  logic [PWD-1:0] fb_prio = 0, tx_prio, sk_prio;
  logic [TW-1:0] new_tag = 0, fb_tag = 0, tx_tag;
  logic tx_valid;
  logic [LW-1:0] loss_cnt;

  always #2 clk = ~clk;

  fbk_inport_ctl #(.ADDR_W(AW), .PRIO_W(PWD), .TAG_W(TW), .DEPTH(DEP), .SKEW(SK), .LOSS_W(LW)) u_fbk_inport_ctl (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
    .new_valid(new_valid), .new_addr(new_addr), .new_tag(new_tag),
    .fb_valid(fb_valid), .fb_addr(fb_addr), .fb_prio(fb_prio), .fb_tag(fb_tag),
    .tx_valid(tx_valid), .tx_addr(tx_addr), .tx_prio(tx_prio), .tx_tag(tx_tag),
    .sk_addr(sk_addr), .sk_prio(sk_prio), .loss_cnt(loss_cnt));

  int n_chk = 0, n_bad = 0;
  int q[$];
  int lv = 0, la = 0, lp = 0, lt = 0;
  int ev = 0, ea = 0, ep = 0, et = 0;
  int eloss = 0, s0 = 0, s1 = 0;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic step(input bit sl, input bit nv, input int na, input int nt,
                      input bit fv, input int fa, input int fp, input int ft, input string rq);
    int nev, nea, nep, net, nlv, nla, nlp, nlt;
    bit sendl, popq;
    slot_start = sl; new_valid = nv; new_addr = AW'(na); new_tag = TW'(nt);
    fb_valid = fv; fb_addr = AW'(fa); fb_prio = PWD'(fp); fb_tag = TW'(ft);
    sendl = sl && lv != 0;
    popq  = sl && lv == 0 && q.size() > 0;
    nev = ev; nea = ea; nep = ep; net = et;
    if (sl) begin
      if (lv != 0) begin nev = 1; nea = la; nep = lp; net = lt; end
      else if (q.size() > 0) begin nev = 1; nea = q[0] / 64; nep = 1; net = q[0] % 64; end
      else begin nev = 0; nea = 0; nep = 0; net = 0; end
    end
    if (popq) void'(q.pop_front());
    if (nv) begin
      if (q.size() < DEP) q.push_back(na * 64 + nt);
      else if (eloss < 255) eloss++;
    end
    nlv = lv; nla = la; nlp = lp; nlt = lt;
    if (fv && fp != 0 && fp != PMAX && (lv == 0 || sendl)) begin
      nlv = 1; nla = fa; nlp = fp + 1; nlt = ft;
    end else if (sendl) nlv = 0;
    s1 = s0; s0 = ea * 4 + ep;
    ev = nev; ea = nea; ep = nep; et = net;
    lv = nlv; la = nla; lp = nlp; lt = nlt;
    @(negedge clk);
    chk(rq, "tx cell", {tx_valid, tx_addr, tx_prio, tx_tag}, ev * 1024 + ea * 256 + ep * 64 + et);
    chk("R7", "loss_cnt", int'(loss_cnt), eloss);
    chk("R9", "skew hdr", {sk_addr, sk_prio}, s1);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "tx after reset", {tx_valid, tx_addr, tx_prio, tx_tag}, 0);
    chk("R1", "skew after reset", {sk_addr, sk_prio}, 0);
    chk("R1", "loss after reset", int'(loss_cnt), 0);
    rst_n = 1;
    // R4: empty slot
    step(1, 0, 0, 0, 0, 0, 0, 0, "R4");
    // R3: FIFO order, priority 1
    step(0, 1, 2, 11, 0, 0, 0, 0, "R10");
    step(0, 1, 1, 22, 0, 0, 0, 0, "R10");
    step(0, 1, 3, 33, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R4");
    // R7: overfill then drain
    for (int i = 0; i < 10; i++) step(0, 1, i % 4, i + 40, 0, 0, 0, 0, "R7");
    step(1, 1, 1, 60, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 9; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R2 / R6: retry ahead of queue
    step(0, 1, 0, 5, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 1, 3, 1, 9, "R6");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R5: illegal priorities discarded
    step(0, 0, 0, 0, 1, 2, 0, 7, "R5");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 1, 2, 3, 7, "R5");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R8: feedback on the draining slot edge, and feedback into an occupied slot
    step(0, 0, 0, 0, 1, 1, 1, 12, "R6");
    step(0, 0, 0, 0, 1, 3, 1, 14, "R8");
    step(1, 0, 0, 0, 1, 2, 2, 13, "R8");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R4");
    // near-exhaustive sweep over event mixes and feedback priorities
    for (int i = 0; i < 960; i++)
      step((i % 3) != 1, (i % 5) < 3, (i * 7) % 4, i % 64,
           (i % 4) == 2, (i / 3) % 4, (i / 4) % 4, (i * 5) % 64, "R2");
    // R7 saturation
    for (int i = 0; i < 300; i++) step(0, 1, 1, 1, 0, 0, 0, 0, "R7");
    chk("R7", "loss saturated", int'(loss_cnt), 255);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule